// File: doc/BRIEF.md
# Multi-Wire Phase Encoding Controller

This block sends one permutation of its output wires per word, by raising the wires one at a time in a chosen order. The order comes from a pairwise precedence description. Every unordered wire pair (i, j) with i < j has its own dual-rail input: one rail says the lower wire goes first, the other says the higher wire goes first, and neither rail means that pair is not yet decided. Together the rails form an N x N Boolean precedence matrix with a zero diagonal.

A wire may rise once every pair that involves it has been decided and every wire that must precede it is already high. A pair that is still undecided holds back only its own two wires. When all wires are high the block raises `done`. It then waits for the spacer, with every rail low, and at that point drops all wires in one edge and re-arms for the next word. If both rails of one pair are high at once, this is a protocol violation: the block freezes its outputs and flags it until reset. The pair inputs are dual-rail and use the return-to-spacer protocol, so they carry no valid/ready handshake and exert no back-pressure. The source must simply hold the rails steady until `done` and then return them to the spacer.

Top module: `phase_encoder`

## Requirements
- R1: During and right after reset, `wire_out` is all zero, and `done` and `proto_err` are 0.
- R2: Pair (i, j) with i < j uses bit p = i*N - i*(i+1)/2 + (j-i-1) of `pair_lo_first` and `pair_hi_first`. For N=4 the order is (0,1),(0,2),(0,3),(1,2),(1,3),(2,3). `pair_lo_first[p]`=1 means wire i rises before wire j. `pair_hi_first[p]`=1 means wire j rises before wire i.
- R3: A wire rises only when every pair that involves it is decided and every wire ordered before it is already high. It rises on the first clock edge at which both conditions hold.
- R4: At most one wire rises per clock edge. For a fully decided acyclic matrix, the rise order equals the encoded permutation.
- R5: An undecided pair stalls only its two wires. Other wires whose pairs are all decided still rise.
- R6: `done` rises on the same edge as the last wire, so all wires are high whenever `done` is 1. It stays high while any rail is nonzero.
- R7: While `done` is 1 and every rail is low, one edge clears all wires together and clears `done`. While any rail is still high, the outputs hold.
- R8: If both rails of any pair are high, `proto_err` rises on the next edge and `wire_out` stays frozen. Both persist until reset, whatever the rails do afterwards.
- R9: After the spacer, the next word is encoded again with a correct order.
- R10: Wires that lie on a precedence cycle never rise. A wire outside the cycle whose constraints are met still rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pair_lo_first | input | N*(N-1)/2 | Rail for each pair: lower-indexed wire goes first |
| pair_hi_first | input | N*(N-1)/2 | Rail for each pair: higher-indexed wire goes first |
| wire_out | output | N | Phase-encoded output wires |
| done | output | 1 | All wires high; waiting for the spacer |
| proto_err | output | 1 | Sticky flag: both rails of some pair were high |

## Verification
Five full permutations are sent back to back, including the identity, the reverse and two scrambled orders. Because each one produces a different rise sequence, they tell a correct pair-to-bit mapping and rail polarity apart from a swapped or shifted one. A matrix with one undecided pair shows that a stall stays local. A three-wire precedence cycle with one free wire shows that a cycle blocks only its members. Holding some rails high after `done` separates "wait for the full spacer" from "clear early", and a clash on one pair in mid-word shows that the error freezes the outputs and stays set.

// File: rtl/pe_pkg.sv
package pe_pkg;

  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,
    ST_DONE  = 2'd1,
    ST_FAULT = 2'd2
  } pe_state_e;

  // Bit position of unordered pair (lo, hi), lo < hi, among n wires.
  function automatic int pair_idx(input int lo, input int hi, input int n);
    return lo * n - (lo * (lo + 1)) / 2 + (hi - lo - 1);
  endfunction

endpackage

// File: rtl/pe_matrix.sv
module pe_matrix #(
  parameter int N = 4,
  localparam int NP = N * (N - 1) / 2
) (
  input  logic [NP-1:0]  lo_first,
  input  logic [NP-1:0]  hi_first,
  output logic [N*N-1:0] prec,      // prec[a*N+b]: wire a must precede wire b
  output logic [N-1:0]   decided,   // every pair touching the wire is resolved
  output logic           clash      // some pair has both rails high
);

  logic [NP-1:0] resolved;
  assign resolved = lo_first | hi_first;
  assign clash    = |(lo_first & hi_first);

  for (genvar ga = 0; ga < N; ga++) begin : g_row
    for (genvar gb = 0; gb < N; gb++) begin : g_col
      if (ga < gb) begin : g_upper
        localparam int P = pe_pkg::pair_idx(ga, gb, N);
        assign prec[ga*N+gb] = lo_first[P];
      end else if (ga > gb) begin : g_lower
        localparam int P = pe_pkg::pair_idx(gb, ga, N);
        assign prec[ga*N+gb] = hi_first[P];
      end else begin : g_diag
        assign prec[ga*N+gb] = 1'b0;
      end
    end
  end

  always_comb begin
    for (int w = 0; w < N; w++) begin
      decided[w] = 1'b1;
      for (int o = 0; o < N; o++) begin
        if (o < w)      decided[w] = decided[w] & resolved[pe_pkg::pair_idx(o, w, N)];
        else if (o > w) decided[w] = decided[w] & resolved[pe_pkg::pair_idx(w, o, N)];
      end
    end
  end

endmodule

// File: rtl/pe_eligible.sv
module pe_eligible #(
  parameter int N = 4
) (
  input  logic [N*N-1:0] prec,
  input  logic [N-1:0]   decided,
  input  logic [N-1:0]   fired,
  output logic [N-1:0]   ready
);

  always_comb begin
    for (int w = 0; w < N; w++) begin
      ready[w] = ~fired[w] & decided[w];
      for (int o = 0; o < N; o++) begin
        if (prec[o*N+w] && !fired[o]) ready[w] = 1'b0;
      end
    end
  end

endmodule

// File: rtl/pe_pick.sv
module pe_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);

  // Lowest index wins; keeps the firing rate at one wire per edge even if
  // the rails change in mid-word and expose several candidates.
  always_comb begin
    logic taken;
    taken = 1'b0;
    grant = '0;
    for (int w = 0; w < N; w++) begin
      if (req[w] && !taken) begin
        grant[w] = 1'b1;
        taken    = 1'b1;
      end
    end
  end

endmodule

// File: rtl/phase_encoder.sv
module phase_encoder #(
  parameter int N = 4,
  localparam int NP = N * (N - 1) / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NP-1:0] pair_lo_first,
  input  logic [NP-1:0] pair_hi_first,
  output logic [N-1:0]  wire_out,
  output logic          done,
  output logic          proto_err
);

  import pe_pkg::*;

  pe_state_e      state_q;
  logic [N-1:0]   wire_q;
  logic [N*N-1:0] prec;
  logic [N-1:0]   decided;
  logic           clash;
  logic [N-1:0]   ready;
  logic [N-1:0]   grant;
  logic [N-1:0]   next_wires;
  logic           spacer;

  pe_matrix #(.N(N)) u_matrix (
    .lo_first (pair_lo_first),
    .hi_first (pair_hi_first),
    .prec     (prec),
    .decided  (decided),
    .clash    (clash)
  );

  pe_eligible #(.N(N)) u_elig (
    .prec    (prec),
    .decided (decided),
    .fired   (wire_q),
    .ready   (ready)
  );

  pe_pick #(.N(N)) u_pick (
    .req   (ready),
    .grant (grant)
  );

  assign next_wires = wire_q | grant;
  assign spacer     = ~|(pair_lo_first | pair_hi_first);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_ARMED;
      wire_q  <= '0;
    end else begin
      case (state_q)
        ST_ARMED: begin
          if (clash) begin
            state_q <= ST_FAULT;
          end else begin
            wire_q <= next_wires;
            if (&next_wires) state_q <= ST_DONE;
          end
        end
        ST_DONE: begin
          if (clash) begin
            state_q <= ST_FAULT;
          end else if (spacer) begin
            wire_q  <= '0;
            state_q <= ST_ARMED;
          end
        end
        default: begin
          state_q <= ST_FAULT;
        end
      endcase
    end
  end

  assign wire_out  = wire_q;
  assign done      = (state_q == ST_DONE);
  assign proto_err = (state_q == ST_FAULT);

  AST_ONE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wire_out & ~$past(wire_out)) <= 1); // R4

  AST_RISE_DECIDED: assert property (@(posedge clk) disable iff (!rst_n)
    (wire_out & ~$past(wire_out) & ~$past(decided)) == '0); // R3

  AST_DONE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (&wire_out)); // R6

  AST_DROP_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    (|wire_out) |=> (((wire_out & $past(wire_out)) == $past(wire_out)) || (wire_out == '0))); // R7

  AST_FAULT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> (proto_err && $stable(wire_out))); // R8

  AST_CLASH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    clash |=> proto_err); // R8

endmodule

// File: tb/tb_phase_encoder.sv
module tb_phase_encoder;

  localparam int N  = 4;
  localparam int NP = N * (N - 1) / 2;
  localparam int NV = 5;

  // Slot k of each entry (bits 2k+1:2k) holds the wire that rises k-th.
  localparam logic [7:0] ORDERS [NV] = '{
    8'b11_10_01_00,  // 0,1,2,3
    8'b10_11_01_00,  // 0,1,3,2
    8'b00_01_10_11,  // 3,2,1,0
    8'b01_11_00_10,  // 2,0,3,1
    8'b10_00_11_01   // 1,3,0,2
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NP-1:0] lo_first;
  logic [NP-1:0] hi_first;
  logic [N-1:0]  wire_out;
  logic          done;
  logic          proto_err;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  phase_encoder #(.N(N)) dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .pair_lo_first (lo_first),
    .pair_hi_first (hi_first),
    .wire_out      (wire_out),
    .done          (done),
    .proto_err     (proto_err)
  );

  function automatic int pidx(input int lo, input int hi);
    return lo * N - (lo * (lo + 1)) / 2 + (hi - lo - 1);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_order(input logic [7:0] ord);
    int pos [N];
    for (int k = 0; k < N; k++) pos[ord[2*k +: 2]] = k;
    lo_first = '0;
    hi_first = '0;
    for (int a = 0; a < N; a++)
      for (int b = a + 1; b < N; b++)
        if (pos[a] < pos[b]) lo_first[pidx(a, b)] = 1'b1;
        else                 hi_first[pidx(a, b)] = 1'b1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    lo_first = '0;
    hi_first = '0;
    repeat (2) tick();
    rst_n = 1'b1;
    tick();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [N-1:0] mask;
    rst_n    = 1'b0;
    lo_first = '0;
    hi_first = '0;
    repeat (3) tick();
    chk("R1 wires in reset", wire_out, 0);
    chk("R1 done in reset", done, 0);
    chk("R1 err in reset", proto_err, 0);
    rst_n = 1'b1;
    tick();
    tick();
    chk("R1 idle after reset", {proto_err, done, wire_out}, 0);

    // Table of permutations sent back to back
    for (int v = 0; v < NV; v++) begin
      set_order(ORDERS[v]);
      mask = '0;
      for (int k = 0; k < N; k++) begin
        tick();
        mask[ORDERS[v][2*k +: 2]] = 1'b1;
        chk(v == 0 ? "R4 R2 R3 order" : "R9 R4 R2 order", wire_out, mask);
        chk("R6 done timing", done, (k == N - 1) ? 1 : 0);
      end
      tick();
      chk("R6 done held", {done, wire_out}, {1'b1, {N{1'b1}}});
      lo_first = '0;
      hi_first = '0;
      tick();
      chk("R7 drop together", {done, wire_out}, 0);
    end

    // R7: partial spacer keeps outputs
    set_order(ORDERS[2]);
    repeat (N) tick();
    lo_first[0] = 1'b0;
    hi_first[0] = 1'b0;
    tick();
    tick();
    chk("R7 hold on partial spacer", {done, wire_out}, {1'b1, {N{1'b1}}});
    lo_first = '0;
    hi_first = '0;
    tick();
    chk("R7 clear on full spacer", {done, wire_out}, 0);

    // R5: pair (2,3) undecided stalls wires 2,3 only
    set_order(ORDERS[0]);
    lo_first[pidx(2, 3)] = 1'b0;
    repeat (4) tick();
    chk("R5 local stall", wire_out, 4'b0011);
    chk("R5 no done while stalled", done, 0);
    lo_first[pidx(2, 3)] = 1'b1;
    tick();
    chk("R5 R3 resume", wire_out, 4'b0111);
    tick();
    chk("R5 finish", {done, wire_out}, 5'b11111);
    lo_first = '0;
    hi_first = '0;
    tick();

    // R10: cycle 0<1<2<0, wire 3 first of all
    lo_first = '0;
    hi_first = '0;
    lo_first[pidx(0, 1)] = 1'b1;
    lo_first[pidx(1, 2)] = 1'b1;
    hi_first[pidx(0, 2)] = 1'b1;
    hi_first[pidx(0, 3)] = 1'b1;
    hi_first[pidx(1, 3)] = 1'b1;
    hi_first[pidx(2, 3)] = 1'b1;
    repeat (5) tick();
    chk("R10 cycle blocks members", wire_out, 4'b1000);
    chk("R10 no done", done, 0);
    do_reset();

    // R8: clash in mid-word
    set_order(ORDERS[0]);
    tick();
    tick();
    chk("R8 pre-clash", wire_out, 4'b0011);
    hi_first[pidx(2, 3)] = 1'b1;
    tick();
    chk("R8 flag", proto_err, 1);
    chk("R8 frozen", wire_out, 4'b0011);
    hi_first[pidx(2, 3)] = 1'b0;
    tick();
    tick();
    chk("R8 frozen after clash gone", {proto_err, wire_out}, 5'b10011);
    lo_first = '0;
    tick();
    chk("R8 sticky through spacer", {proto_err, done, wire_out}, 6'b100011);
    do_reset();
    chk("R8 R1 cleared by reset", {proto_err, done, wire_out}, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule